// File: doc/BRIEF.md
# Cascaded Serial DAC Update Controller

This block is a host-side writer for a string of serial DACs that are wired in cascade. All devices share the serial clock and an active-low select/load strobe. The block drives the data input of the nearest device, and each device passes its shift-register output on to the next one. One request carries a code for every device, packed into a single vector. The block shifts the whole vector out as one continuous burst. When the burst ends, the strobe rises once, and every device moves its shifted word into its output register at the same moment.

Requests enter through a valid/ready handshake. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_codes` is captured on that edge. While a transfer is running, `req_ready` stays low. Back-pressure therefore lasts from the accepting edge until one cycle after the `done` pulse, and a requester that holds `req_valid` high is served in the first idle cycle. Each serial timing interval is a parameter counted in system clock cycles: setup before the first rise, clock high, clock low, and strobe-high width. Each value is the nanosecond minimum rounded up to whole cycles.

Top module: `dac_chain_writer`

## Requirements
- R1: During and right after reset, `sclk` is 0, `ld_n` is 1, `sdata` is 0, `done` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 only in the idle state. A request is accepted on an edge with `req_valid` and `req_ready` both high. `req_ready` is 0 from that edge until the cycle after the `done` pulse, and a request held during that time is not taken early.
- R3: `ld_n` falls in the cycle after the accepting edge. It then stays low with `sclk` low for `T_SETUP` cycles before the first rise of `sclk`.
- R4: Each serial bit is a high phase of exactly `T_HIGH` cycles followed by a low phase of exactly `T_LOW` cycles. A transfer has exactly `NUM_DEV*WORD_W` rising edges.
- R5: The serial stream is `req_codes` sent from bit `NUM_DEV*WORD_W-1` down to bit 0. The code for device k is `req_codes[k*WORD_W +: WORD_W]`, so the farthest device's code goes first, and each code goes MSB first. `sdata` changes only as `sclk` falls, and it holds still while `sclk` is high.
- R6: After the last high phase, `sclk` stays low for `T_LOW` cycles with `ld_n` still low. Only then does `ld_n` rise, so the clock is low whenever the strobe changes.
- R7: `ld_n` stays high for `T_LOAD` cycles. `done` is then 1 for exactly one cycle, and `req_ready` returns to 1 in the following cycle.
- R8: In a modelled chain, where each device shifts on the rising edge of `sclk` while `ld_n` is low and latches on the rising edge of `ld_n`, device k holds code k after every transfer.
- R9: `sclk` is never high while `ld_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_codes | input | NUM_DEV*WORD_W | Packed codes, device k in slice k |
| sclk | output | 1 | Serial clock to all devices, idles low |
| sdata | output | 1 | Serial data into the nearest device |
| ld_n | output | 1 | Shared select/load strobe, active low, idles high |
| done | output | 1 | One-cycle pulse after the strobe-high interval |

## Verification
Every output is due at a fixed cycle offset from the accepting edge. `ld_n` falls one cycle later. The first `sclk` rise comes `T_SETUP+1` cycles after that edge. Each bit then occupies `T_HIGH+T_LOW` cycles, the strobe rises after the final low phase, and `done` follows `T_LOAD` cycles after the strobe rises. When the bench model sees a request accepted, it expands it into a queue of per-cycle expected values. On every falling clock edge it pops one entry and compares it with all outputs, so each result is checked in exactly the cycle it is due. A behavioural chain of device shift registers then confirms which code each device latched.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ASSERT_CS = 3'd1,
    ST_SHIFT_HI  = 3'd2,
    ST_SHIFT_LO  = 3'd3,
    ST_LOAD_HI   = 3'd4,
    ST_DONE      = 3'd5
  } wr_state_t;
endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // a phase is only re-armed once the previous one has fully elapsed
  AST_TIMER_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt_q == '0)); // R4
endmodule

// File: rtl/dac_shift_out.sv
module dac_shift_out #(
  parameter int TOTAL_W = 36
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [TOTAL_W-1:0] load_data,
  input  logic               shift,
  output logic               msb
);
  logic [TOTAL_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= load_data;
    else if (shift) sr_q <= {sr_q[TOTAL_W-2:0], 1'b0};
  end

  assign msb = sr_q[TOTAL_W-1];

  AST_SHIFT_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift)); // R5
endmodule

// File: rtl/dac_chain_writer.sv
module dac_chain_writer
  import dac_chain_pkg::*;
#(
  parameter int NUM_DEV = 3,
  parameter int WORD_W  = 12,
  parameter int T_SETUP = 5,
  parameter int T_HIGH  = 10,
  parameter int T_LOW   = 10,
  parameter int T_LOAD  = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [NUM_DEV*WORD_W-1:0] req_codes,
  output logic                      sclk,
  output logic                      sdata,
  output logic                      ld_n,
  output logic                      done
);
  localparam int TOTAL_W = NUM_DEV * WORD_W;
  localparam int BITS_W  = $clog2(TOTAL_W + 1);
  localparam int T_MAX_A = (T_SETUP > T_HIGH) ? T_SETUP : T_HIGH;
  localparam int T_MAX_B = (T_LOW > T_LOAD) ? T_LOW : T_LOAD;
  localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
  localparam int TMR_W   = $clog2(T_MAX + 1);

  wr_state_t         state_q, state_d;
  logic [BITS_W-1:0] bits_q;
  logic              tmr_load, tmr_zero, shift_en, accept;
  logic [TMR_W-1:0]  tmr_val;

  assign accept = req_valid && req_ready;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    shift_en = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_ASSERT_CS; tmr_load = 1'b1; tmr_val = TMR_W'(T_SETUP - 1);
      end
      ST_ASSERT_CS: if (tmr_zero) begin
        state_d = ST_SHIFT_HI; tmr_load = 1'b1; tmr_val = TMR_W'(T_HIGH - 1);
      end
      ST_SHIFT_HI: if (tmr_zero) begin
        state_d = ST_SHIFT_LO; tmr_load = 1'b1; tmr_val = TMR_W'(T_LOW - 1);
        shift_en = 1'b1;
      end
      ST_SHIFT_LO: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (bits_q == '0) begin
          state_d = ST_LOAD_HI; tmr_val = TMR_W'(T_LOAD - 1);
        end else begin
          state_d = ST_SHIFT_HI; tmr_val = TMR_W'(T_HIGH - 1);
        end
      end
      ST_LOAD_HI: if (tmr_zero) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept)        bits_q <= BITS_W'(TOTAL_W);
      else if (shift_en) bits_q <= bits_q - 1'b1;
    end
  end

  dac_phase_timer #(.CNT_W(TMR_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
  );

  dac_shift_out #(.TOTAL_W(TOTAL_W)) shreg_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(req_codes),
    .shift(shift_en), .msb(sdata)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign sclk      = (state_q == ST_SHIFT_HI);
  assign ld_n      = !((state_q == ST_ASSERT_CS) || (state_q == ST_SHIFT_HI) ||
                       (state_q == ST_SHIFT_LO));
  assign done      = (state_q == ST_DONE);

  AST_CLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !ld_n); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |-> !req_ready); // R2
  AST_STROBE_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_n) |-> !sclk); // R3
  AST_STROBE_RISE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_n) |-> (!sclk && !$past(sclk))); // R6
  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata)); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ld_n && $past(ld_n))); // R7
endmodule

// File: tb/dac_chain_writer_tb_top.sv
`timescale 1ns/1ps
module dac_chain_writer_tb_top;
  localparam int NUM_DEV = 3;
  localparam int WORD_W  = 12;
  localparam int T_SETUP = 5;
  localparam int T_HIGH  = 10;
  localparam int T_LOW   = 10;
  localparam int T_LOAD  = 13;
  localparam int TOTAL_W = NUM_DEV * WORD_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [TOTAL_W-1:0] req_codes = '0;
  logic req_ready, sclk, sdata, ld_n, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dac_chain_writer #(.NUM_DEV(NUM_DEV), .WORD_W(WORD_W), .T_SETUP(T_SETUP),
    .T_HIGH(T_HIGH), .T_LOW(T_LOW), .T_LOAD(T_LOAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_codes(req_codes), .sclk(sclk), .sdata(sdata), .ld_n(ld_n), .done(done));

  // expected per-cycle outputs: {ready, done, ld_n, sclk, sdata}
  logic [4:0] exp_q[$];
  logic [TOTAL_W-1:0] sent_q[$];

  // behavioural device chain
  logic [WORD_W-1:0] dev_sr [NUM_DEV];
  logic [WORD_W-1:0] dev_out[NUM_DEV];
  initial for (int k = 0; k < NUM_DEV; k++) begin dev_sr[k] = '0; dev_out[k] = '0; end

  always @(posedge sclk) if (!ld_n) begin
    for (int k = NUM_DEV - 1; k > 0; k--)
      dev_sr[k] <= {dev_sr[k][WORD_W-2:0], dev_sr[k-1][WORD_W-1]};
    dev_sr[0] <= {dev_sr[0][WORD_W-2:0], sdata};
  end
  always @(posedge ld_n) if (rst_n)
    for (int k = 0; k < NUM_DEV; k++) dev_out[k] = dev_sr[k];

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, expv, cycles);
    end
  endtask

  task automatic build_expect(input logic [TOTAL_W-1:0] v);
    for (int i = 0; i < T_SETUP; i++) exp_q.push_back({1'b0, 1'b0, 1'b0, 1'b0, v[TOTAL_W-1]});
    for (int b = TOTAL_W - 1; b >= 0; b--) begin
      for (int i = 0; i < T_HIGH; i++) exp_q.push_back({1'b0, 1'b0, 1'b0, 1'b1, v[b]});
      for (int i = 0; i < T_LOW; i++)
        exp_q.push_back({1'b0, 1'b0, 1'b0, 1'b0, (b > 0) ? v[b-1] : 1'b0});
    end
    for (int i = 0; i < T_LOAD; i++) exp_q.push_back(5'b00100);
    exp_q.push_back(5'b01100);
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      logic [4:0] e;
      logic [TOTAL_W-1:0] got;
      bit idle_entry;
      idle_entry = (exp_q.size() == 0);
      e = idle_entry ? 5'b10100 : exp_q.pop_front();
      check("R2", "req_ready", req_ready, e[4]);
      check("R7", "done", done, e[3]);
      check("R3", "ld_n", ld_n, e[2]);
      check("R4", "sclk", sclk, e[1]);
      check("R5", "sdata", sdata, e[0]);
      check("R9", "sclk_while_deselected", sclk & ld_n, 1'b0);
      if (e[3]) begin
        got = sent_q.pop_front();
        for (int k = 0; k < NUM_DEV; k++)
          check("R8", $sformatf("device%0d_code", k), dev_out[k], got[k*WORD_W +: WORD_W]);
      end
      if (idle_entry && req_valid) begin
        sent_q.push_back(req_codes);
        build_expect(req_codes);
      end
    end
  end

  task automatic send(input logic [TOTAL_W-1:0] v);
    @(posedge clk); #1;
    req_codes = v;
    req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0 || !req_ready);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset_sclk", sclk, 1'b0);
    check("R1", "reset_ld_n", ld_n, 1'b1);
    check("R1", "reset_sdata", sdata, 1'b0);
    check("R1", "reset_done", done, 1'b0);
    check("R1", "reset_ready", req_ready, 1'b1);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // distinct code per device, farthest first in the stream
    send({12'hABC, 12'h123, 12'h5A5});
    wait_idle();
    // back-to-back: second request held while the first is busy (R2)
    send({12'hFFF, 12'h000, 12'hFFF});
    send({12'h000, 12'hFFF, 12'h800});
    wait_idle();
    send({12'h001, 12'h800, 12'h7FE});
    wait_idle();
    send({TOTAL_W{1'b0}});
    wait_idle();
    send({TOTAL_W{1'b1}});
    wait_idle();
    repeat (5) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired, no completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule